// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block produces the column address for each data beat of a single read or write burst in a DDR2-style memory model or controller. A read or write command brings a start column, and the mode setting supplies two things: a burst length of four or eight beats and an ordering of sequential or interleaved. After the command is accepted, the block puts out one column address per clock and marks the final beat. It also reports whether the current burst is a read or a write.

The block also decides what happens to a command that arrives while a burst is running. On the final beat, a new command continues the data stream with no gap. Before the final beat, the rules depend on the burst length. A four-beat burst can never be cut short. An eight-beat burst can be restarted only by a command of the same kind. Commands that are not allowed, burst-stop requests and commands issued under an unsupported burst-length code are dropped, and each raises a one-cycle error pulse.

The control is a two-state machine. `ST_IDLE` moves to `ST_BURST` when a command is accepted. `ST_BURST` stays in `ST_BURST` while beats advance, and it also stays there when a command is accepted (seamless continuation or a legal restart). `ST_BURST` returns to `ST_IDLE` after the final beat if no command is accepted on that beat.

Top module: `ddr_burst_seq`

## Requirements
- R1: The burst length comes from `mode_cfg[2:0]`: code 3'b010 selects four beats and code 3'b011 selects eight beats. The ordering comes from `mode_cfg[3]`: 0 selects sequential and 1 selects interleaved. A read or write issued under any other length code starts no burst and raises `err_mode` for one cycle.
- R2: When a command is accepted at a rising edge, `beat_valid` goes high from that edge and stays high for exactly BL cycles. `beat_last` is high only on the final one of those cycles.
- R3: In a four-beat sequential burst, beat n carries column bits [1:0] equal to (start[1:0] + n) mod 4.
- R4: In interleaved order, beat n carries start XOR n over the low two bits (four-beat bursts) or over the low three bits (eight-beat bursts).
- R5: In an eight-beat sequential burst, beat n carries bits [1:0] = (start[1:0] + n) mod 4 and bit 2 = start[2] XOR (n >= 4).
- R6: Column bits above the burst window keep the start value for the whole burst. These are bits [COL_W-1:2] for four beats and bits [COL_W-1:3] for eight beats.
- R7: During a four-beat burst, a read or write on any beat except the final one is dropped, raises `err_illegal` for one cycle, and leaves the burst running unchanged.
- R8: During an eight-beat burst, a read issued before the final beat of a read burst, or a write issued before the final beat of a write burst, restarts the sequence at the new column with beat 0 in the next cycle. A command of the other kind raises `err_illegal` and is dropped.
- R9: A read or write accepted on the final beat, or while idle, starts its beat 0 in the next cycle, whatever the previous command kind was.
- R10: A burst-stop command (op 2'b11) raises `err_stop` for one cycle and has no effect on the burst.
- R11: `beat_write` is 1 for a write burst (op 2'b10) and 0 for a read burst (op 2'b01). Op 2'b00 is no command.
- R12: After reset the block is idle with all outputs low. At most one error pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 4 | Mode field: [2:0] burst length code, [3] ordering |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 01 read, 10 write, 11 burst stop, 00 none |
| cmd_col | input | COL_W | Start column of the command |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |
| beat_write | output | 1 | Current burst is a write |
| err_illegal | output | 1 | One-cycle pulse: forbidden interruption dropped |
| err_stop | output | 1 | One-cycle pulse: burst stop requested |
| err_mode | output | 1 | One-cycle pulse: unsupported length code |

## Verification
The bound checker watches every cycle for the following:
- four-beat bursts advance one beat per clock without a break;
- beat 0 always carries the start column;
- the bits above the window never move;
- the final-beat strobe appears only inside a burst;
- a stop request always produces its pulse and never ends the burst;
- at most one error pulse fires in any cycle.

The exact address order of each ordering and length, the restart of an eight-beat burst at a new column, the gap-free continuation on the final beat, and the mode-code rejection depend on command timing. Only the bench's directed sequences and its randomised command stream, compared against a separately computed model, can show these.

// File: rtl/ddr_burst_pkg.sv
`timescale 1ns/1ps
package ddr_burst_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_STOP = 2'b11
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_BURST
    } st_e;

    localparam logic [2:0] BLC_4    = 3'b010;
    localparam logic [2:0] BLC_8    = 3'b011;
    localparam int         TYPE_BIT = 3;
    localparam int         IDX_W    = 3;
endpackage

// File: rtl/burst_order.sv
`timescale 1ns/1ps
module burst_order #(
    parameter int COL_W = 10,
    parameter int IDX_W = 3
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [IDX_W-1:0] idx,
    input  logic             bl8,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [1:0] low_seq;
    logic [1:0] low_ilv;

    assign low_seq = start_col[1:0] + idx[1:0];
    assign low_ilv = start_col[1:0] ^ idx[1:0];

    always_comb begin
        col      = start_col;
        col[1:0] = ilv ? low_ilv : low_seq;
        // bit 2 flips after the first nibble in both orderings
        if (bl8) begin
            col[2] = start_col[2] ^ idx[2];
        end
    end
endmodule

// File: rtl/cmd_judge.sv
`timescale 1ns/1ps
module cmd_judge
    import ddr_burst_pkg::*;
(
    input  logic       busy,
    input  logic       on_last,
    input  logic       cur_bl8,
    input  logic       cur_write,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       len_ok,
    output logic       start,
    output logic       bad_interrupt,
    output logic       stop_req,
    output logic       bad_len
);
    logic is_rw;
    logic slot_free;
    logic may_cut;

    assign is_rw     = cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR);
    assign slot_free = !busy || on_last;
    assign may_cut   = busy && !on_last && cur_bl8 && ((cmd_op == OP_WR) == cur_write);

    assign bad_len       = is_rw && !len_ok;
    assign stop_req      = cmd_valid && (cmd_op == OP_STOP);
    assign start         = is_rw && len_ok && (slot_free || may_cut);
    assign bad_interrupt = is_rw && len_ok && !slot_free && !may_cut;
endmodule

// File: rtl/ddr_burst_seq.sv
`timescale 1ns/1ps
module ddr_burst_seq
    import ddr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_cfg,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [COL_W-1:0] cmd_col,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last,
    output logic             beat_write,
    output logic             err_illegal,
    output logic             err_stop,
    output logic             err_mode
);
    localparam logic [IDX_W-1:0] LAST4 = IDX_W'(3);
    localparam logic [IDX_W-1:0] LAST8 = IDX_W'(7);

    st_e              state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic [COL_W-1:0] lat_col;
    logic             lat_bl8, lat_ilv, lat_wr;

    logic mode_len_ok, mode_bl8, mode_ilv;
    logic on_last, start;
    logic j_bad_int, j_stop, j_bad_len;

    assign mode_len_ok = (mode_cfg[2:0] == BLC_4) || (mode_cfg[2:0] == BLC_8);
    assign mode_bl8    = (mode_cfg[2:0] == BLC_8);
    assign mode_ilv    = mode_cfg[TYPE_BIT];

    assign on_last = (state_q == ST_BURST) && (cnt_q == (lat_bl8 ? LAST8 : LAST4));

    cmd_judge u_judge (
        .busy          (state_q == ST_BURST),
        .on_last       (on_last),
        .cur_bl8       (lat_bl8),
        .cur_write     (lat_wr),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .len_ok        (mode_len_ok),
        .start         (start),
        .bad_interrupt (j_bad_int),
        .stop_req      (j_stop),
        .bad_len       (j_bad_len)
    );

    burst_order #(.COL_W(COL_W), .IDX_W(IDX_W)) u_order (
        .start_col (lat_col),
        .idx       (cnt_q),
        .bl8       (lat_bl8),
        .ilv       (lat_ilv),
        .col       (beat_col)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (start)        state_d = ST_BURST;
                else if (on_last) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // beat counter, burst latches and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            lat_col     <= '0;
            lat_bl8     <= 1'b0;
            lat_ilv     <= 1'b0;
            lat_wr      <= 1'b0;
            err_illegal <= 1'b0;
            err_stop    <= 1'b0;
            err_mode    <= 1'b0;
        end else begin
            if (start) begin
                cnt_q   <= '0;
                lat_col <= cmd_col;
                lat_bl8 <= mode_bl8;
                lat_ilv <= mode_ilv;
                lat_wr  <= (cmd_op == OP_WR);
            end else if (state_q == ST_BURST && !on_last) begin
                cnt_q <= cnt_q + 1'b1;
            end
            err_illegal <= j_bad_int;
            err_stop    <= j_stop;
            err_mode    <= j_bad_len;
        end
    end

    assign beat_valid = (state_q == ST_BURST);
    assign beat_last  = on_last;
    assign beat_write = beat_valid && lat_wr;
endmodule

// File: rtl/ddr_burst_seq_chk.sv
`timescale 1ns/1ps
module ddr_burst_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             beat_valid,
    input logic             beat_last,
    input logic [COL_W-1:0] beat_col,
    input logic             err_illegal,
    input logic             err_stop,
    input logic             err_mode,
    input logic [2:0]       cnt_q,
    input logic [COL_W-1:0] lat_col,
    input logic             lat_bl8
);
    // R2
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R3
    first_beat_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && cnt_q == 3'd0) |-> (beat_col == lat_col));

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_col[COL_W-1:3] == lat_col[COL_W-1:3]));

    // R7
    short_uncut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && !lat_bl8) |=> (beat_valid && cnt_q == $past(cnt_q) + 3'd1));

    // R10
    stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11) |=> err_stop);

    // R10
    stop_harmless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11 && beat_valid && !beat_last) |=> beat_valid);

    // R12
    one_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_illegal, err_stop, err_mode}) <= 1);
endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .beat_valid  (beat_valid),
    .beat_last   (beat_last),
    .beat_col    (beat_col),
    .err_illegal (err_illegal),
    .err_stop    (err_stop),
    .err_mode    (err_mode),
    .cnt_q       (cnt_q),
    .lat_col     (lat_col),
    .lat_bl8     (lat_bl8)
);

// File: tb/ddr_burst_seq_bench.sv
`timescale 1ns/1ps
module ddr_burst_seq_bench;
    localparam int CW = 10;
    localparam logic [3:0] BL4S = 4'b0010, BL4I = 4'b1010, BL8S = 4'b0011, BL8I = 4'b1011;
    localparam logic [1:0] RD = 2'b01, WR = 2'b10, STP = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    mode_cfg = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [CW-1:0] cmd_col = '0;
    logic          beat_valid, beat_last, beat_write;
    logic [CW-1:0] beat_col;
    logic          err_illegal, err_stop, err_mode;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    bit            m_busy, m_bl8, m_ilv, m_wr, m_eill, m_estop, m_emode;
    bit [2:0]      m_cnt;
    logic [CW-1:0] m_col;

    always #10 clk = ~clk;

    ddr_burst_seq #(.COL_W(CW)) u_ddr_burst_seq (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_col(cmd_col), .beat_valid(beat_valid),
        .beat_col(beat_col), .beat_last(beat_last), .beat_write(beat_write),
        .err_illegal(err_illegal), .err_stop(err_stop), .err_mode(err_mode)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] exp_col(logic [CW-1:0] s, bit [2:0] n, bit bl8, bit ilv);
        logic [CW-1:0] r;
        r = s;
        if (ilv) r[1:0] = s[1:0] ^ n[1:0];
        else     r[1:0] = s[1:0] + n[1:0];
        if (bl8) r[2] = s[2] ^ (n >= 3'd4);
        return r;
    endfunction

    task automatic check_model();
        string t;
        logic [CW-1:0] e;
        chk(beat_valid === m_busy, "R2 valid", beat_valid, m_busy);
        if (m_busy) begin
            t = m_ilv ? "R4" : (m_bl8 ? "R5" : "R3");
            e = exp_col(m_col, m_cnt, m_bl8, m_ilv);
            chk(beat_col === e, t, beat_col, e);
            chk(beat_col[CW-1:3] === m_col[CW-1:3], "R6", beat_col, m_col);
            chk(beat_last === (m_cnt == (m_bl8 ? 3'd7 : 3'd3)), "R2 last", beat_last, m_cnt);
            chk(beat_write === m_wr, "R11", beat_write, m_wr);
        end
        chk(err_illegal === m_eill, "R7/R8 illegal", err_illegal, m_eill);
        chk(err_stop === m_estop, "R10", err_stop, m_estop);
        chk(err_mode === m_emode, "R1", err_mode, m_emode);
        chk((32'(err_illegal) + 32'(err_stop) + 32'(err_mode)) <= 1, "R12 errors", {err_illegal, err_stop, err_mode}, 0);
    endtask

    task automatic step(input bit v, input logic [1:0] op, input logic [CW-1:0] col, input logic [3:0] mode);
        bit last, rw, ok, free, cut, st;
        check_model();
        cmd_valid = v; cmd_op = op; cmd_col = col; mode_cfg = mode;
        last = m_busy && (m_cnt == (m_bl8 ? 3'd7 : 3'd3));
        rw   = v && (op == RD || op == WR);
        ok   = (mode[2:0] == 3'b010) || (mode[2:0] == 3'b011);
        free = !m_busy || last;
        cut  = m_busy && !last && m_bl8 && ((op == WR) == m_wr);
        st   = rw && ok && (free || cut);
        m_emode = rw && !ok;
        m_estop = v && (op == STP);
        m_eill  = rw && ok && !free && !cut;
        if (st) begin
            m_busy = 1; m_cnt = 0; m_col = col;
            m_bl8 = mode[0]; m_ilv = mode[3]; m_wr = (op == WR);
        end else if (m_busy) begin
            if (last) m_busy = 0;
            else      m_cnt = m_cnt + 3'd1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'b00, '0, BL4S);
    endtask

    task automatic burst_lit(input string tag, input logic [CW-1:0] col, input logic [3:0] mode,
                             input int n, input logic [23:0] lits);
        step(1, RD, col, mode);
        for (int i = 0; i < n; i++) begin
            chk(beat_col[2:0] === lits[i*3 +: 3], tag, beat_col[2:0], lits[i*3 +: 3]);
            step(0, 2'b00, '0, mode);
        end
    endtask

    initial begin
        logic [31:0] r;
        r = $urandom(32'd20240607);
        m_busy = 0; m_cnt = 0; m_col = '0; m_bl8 = 0; m_ilv = 0; m_wr = 0;
        m_eill = 0; m_estop = 0; m_emode = 0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!beat_valid && !beat_last && !beat_write && !err_illegal && !err_stop && !err_mode,
            "R12 reset", {beat_valid, beat_last, beat_write, err_illegal, err_stop, err_mode}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: start low bits 3 -> 3,0,1,2
        burst_lit("R3 order", 10'h1AB, BL4S, 4, {12'h0, 3'd2, 3'd1, 3'd0, 3'd3});
        // R5: start 6 -> 6,7,4,5,2,3,0,1
        burst_lit("R5 order", 10'h0F6, BL8S, 8, {3'd1, 3'd0, 3'd3, 3'd2, 3'd5, 3'd4, 3'd7, 3'd6});
        // R4: eight-beat start 5 -> 5,4,7,6,1,0,3,2
        burst_lit("R4 order8", 10'h2C5, BL8I, 8, {3'd2, 3'd3, 3'd0, 3'd1, 3'd6, 3'd7, 3'd4, 3'd5});
        // R4: four-beat start 2 -> 2,3,0,1, bit 2 held at 1
        burst_lit("R4 order4", 10'h006, BL4I, 4, {12'h0, 3'd5, 3'd4, 3'd7, 3'd6});

        // R9 seamless read -> write on final beat
        step(1, RD, 10'h040, BL4S);
        idle(3);
        chk(beat_last === 1'b1, "R9 on last", beat_last, 1);
        step(1, WR, 10'h155, BL8S);
        chk(beat_valid && beat_write && beat_col == 10'h155, "R9 seamless", beat_col, 10'h155);
        idle(9);

        // R7 four-beat burst refuses interruption
        step(1, RD, 10'h010, BL4S);
        step(1, WR, 10'h3F0, BL4S);
        chk(err_illegal && beat_col == 10'h011, "R7 uncut", {err_illegal, beat_col}, {1'b1, 10'h011});
        idle(4);

        // R8 eight-beat restart and mixed rejection
        step(1, RD, 10'h020, BL8I);
        step(0, 2'b00, '0, BL8I);
        step(1, RD, 10'h0A8, BL8I);
        chk(beat_col == 10'h0A8 && !err_illegal, "R8 restart", beat_col, 10'h0A8);
        step(1, WR, 10'h300, BL8I);
        chk(err_illegal && !beat_write && beat_col == 10'h0A9, "R8 mixed", {err_illegal, beat_col}, {1'b1, 10'h0A9});
        idle(9);

        // R10 stop is flagged and harmless
        step(1, RD, 10'h100, BL4S);
        step(1, STP, 10'h000, BL4S);
        chk(err_stop && beat_valid && beat_col == 10'h101, "R10 stop", {err_stop, beat_col}, {1'b1, 10'h101});
        idle(4);

        // R1 unsupported length code
        step(1, RD, 10'h100, 4'b0110);
        chk(err_mode && !beat_valid, "R1 bad code", {err_mode, beat_valid}, 2'b10);
        idle(2);

        // random command stream, model-checked
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] md;
            logic [3:0] sel;
            sel = 4'($urandom % 16);
            md  = (sel == 0) ? 4'b0101 : {sel[1], 2'b01, sel[0]};
            step(($urandom % 10) < 4, 2'($urandom), CW'($urandom), md);
        end
        idle(10);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule